// File: doc/BRIEF.md
# Selectable Congruential Random Word Generator

This block produces a stream of 32-bit pseudo-random words from a single state register. Two recurrences are available. The affine recurrence multiplies the state by a fixed constant and adds a second constant. The shift-add recurrence needs no multiplier: it sums the state, the state shifted left by one and the state shifted left by sixteen, then adds one. All arithmetic wraps modulo 2^32.

A client loads a seed and chooses the recurrence with a single seed-load strobe. After that, each advance strobe moves the state one step. In the following cycle the block presents the new state as the output word, together with a one-cycle valid pulse. The recurrence selection is captured only when a seed is loaded, so a stream cannot switch recurrence part of the way through.

Top module: `rng_selectable`

## Requirements
- R1: After synchronous reset, `rnd_word` is 1 and `rnd_valid` is 0. The captured recurrence is affine, so a first advance yields 2862137630.
- R2: When recurrence select value 0 (affine) is captured, an advance sets state to (2147001325 * state + 715136305) mod 2^32.
- R3: When recurrence select value 1 (shift-add) is captured, an advance sets state to (state + 2*state + 65536*state + 1) mod 2^32, which wraps on overflow.
- R4: In shift-add mode an all-zero state advances to 1, so zero is never a fixed point.
- R5: The word presented after an advance is the newly computed state, not the state it was computed from.
- R6: A seed load writes `seed_val` unchanged into the state. The value appears on `rnd_word` in the next cycle, with `rnd_valid` low.
- R7: When `seed_load` and `advance` are both high in one cycle, only the seed load takes effect.
- R8: `rnd_valid` is high for exactly the one cycle after each accepted advance and low after any other cycle. Back-to-back advances keep it high in each of those cycles.
- R9: `mode_sel` is captured only while `seed_load` is high. Changing it at any other time has no effect on later steps.
- R10: With neither strobe high, `rnd_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load `seed_val` into the state and capture `mode_sel` |
| seed_val | input | 32 | Seed value |
| mode_sel | input | 1 | Recurrence select: 0 affine, 1 shift-add |
| advance | input | 1 | Step the state once |
| rnd_word | output | 32 | Current state / output word |
| rnd_valid | output | 1 | One-cycle pulse after an advance |

## Verification
The bench targets several corner cases.

- **Overflow wrap.** A seed of all ones in shift-add mode and a large seed in affine mode must wrap. A design that kept carries or computed in signed form would produce wrong words there.
- **Zero state.** A zero state in shift-add mode must advance to 1. Dropping the constant term would leave the stream stuck at 0.
- **Priority and mode capture.** Simultaneous seed load and advance must load only the seed. A mode flip between seeds must be ignored. A design with reversed priority or a transparent mode input would produce a step result, or the other recurrence's value.
- **Output timing.** The valid flag must pulse after each advance and stay low when idle. A design that returned the previous state would present a word one step behind.

// File: rtl/rng_sel_pkg.sv
package rng_sel_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic {
        MODE_AFFINE   = 1'b0,
        MODE_SHIFTADD = 1'b1
    } rng_mode_e;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_SEED = 2'd1,
        OP_STEP = 2'd2
    } rng_op_e;

    typedef struct packed {
        rng_op_e             op;
        rng_mode_e           mode;
        logic [WORD_W-1:0]   seed;
    } rng_cmd_t;

    // Seed load wins over a step request in the same cycle.
    function automatic rng_op_e decode_op(input logic load, input logic adv);
        if (load)
            return OP_SEED;
        else if (adv)
            return OP_STEP;
        else
            return OP_IDLE;
    endfunction

endpackage

// File: rtl/rng_mode_latch.sv
module rng_mode_latch
    import rng_sel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rng_cmd_t  cmd,
    output rng_mode_e mode_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_AFFINE;
        else if (cmd.op == OP_SEED)
            mode_q <= cmd.mode;
    end

endmodule

// File: rtl/rng_step_unit.sv
module rng_step_unit
    import rng_sel_pkg::*;
#(
    parameter int unsigned       WIDTH    = WORD_W,
    parameter logic [WIDTH-1:0]  MUL_K    = 32'd2147001325,
    parameter logic [WIDTH-1:0]  ADD_K    = 32'd715136305,
    parameter int unsigned       SHIFT_HI = 16
) (
    input  logic [WIDTH-1:0] cur,
    input  rng_mode_e        mode,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] affine_val;
    logic [WIDTH-1:0] shadd_val;

    // Both recurrences wrap naturally at WIDTH bits.
    always_comb begin
        affine_val = (cur * MUL_K) + ADD_K;
        shadd_val  = cur + (cur << 1) + (cur << SHIFT_HI) + ONE;
    end

    always_comb begin
        unique case (mode)
            MODE_AFFINE:   nxt = affine_val;
            MODE_SHIFTADD: nxt = shadd_val;
            default:       nxt = affine_val;
        endcase
    end

endmodule

// File: rtl/rng_state_reg.sv
module rng_state_reg
    import rng_sel_pkg::*;
#(
    parameter int unsigned      WIDTH      = WORD_W,
    parameter logic [WIDTH-1:0] RESET_SEED = 32'd1
) (
    input  logic             clk,
    input  logic             rst,
    input  rng_op_e          op,
    input  logic [WIDTH-1:0] seed,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] state_q,
    output logic             valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_SEED;
            valid_q <= 1'b0;
        end else begin
            unique case (op)
                OP_SEED: begin
                    state_q <= seed;
                    valid_q <= 1'b0;
                end
                OP_STEP: begin
                    state_q <= nxt;
                    valid_q <= 1'b1;
                end
                default: valid_q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/rng_selectable.sv
module rng_selectable
    import rng_sel_pkg::*;
#(
    parameter int unsigned WIDTH = WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_val,
    input  logic             mode_sel,
    input  logic             advance,
    output logic [WIDTH-1:0] rnd_word,
    output logic             rnd_valid
);

    rng_cmd_t         cmd;
    rng_mode_e        mode_q;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] nxt;

    always_comb begin
        cmd.op   = decode_op(seed_load, advance);
        cmd.mode = rng_mode_e'(mode_sel);
        cmd.seed = seed_val;
    end

    rng_mode_latch u_mode (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .mode_q (mode_q)
    );

    rng_step_unit #(.WIDTH(WIDTH)) u_step (
        .cur  (state_q),
        .mode (mode_q),
        .nxt  (nxt)
    );

    rng_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk     (clk),
        .rst     (rst),
        .op      (cmd.op),
        .seed    (cmd.seed),
        .nxt     (nxt),
        .state_q (state_q),
        .valid_q (rnd_valid)
    );

    assign rnd_word = state_q;

endmodule

// File: rtl/rng_selectable_chk.sv
module rng_selectable_chk (
    input logic        clk,
    input logic        rst,
    input logic        seed_load,
    input logic [31:0] seed_val,
    input logic        advance,
    input logic [31:0] rnd_word,
    input logic        rnd_valid,
    input logic        mode_cap
);

    // R8
    valid_after_step_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !seed_load) |=> rnd_valid);

    // R8
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(advance && !seed_load) |=> !rnd_valid);

    // R6
    seed_lands_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> (rnd_word == $past(seed_val)));

    // R10
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && !advance) |=> $stable(rnd_word));

    // R4
    zero_escape_chk: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && advance && mode_cap && rnd_word == 32'd0) |=> (rnd_word == 32'd1));

    // R2
    affine_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && advance && !mode_cap)
        |=> (rnd_word == $past(rnd_word) * 32'd2147001325 + 32'd715136305));

endmodule

bind rng_selectable rng_selectable_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .seed_load (seed_load),
    .seed_val  (seed_val),
    .advance   (advance),
    .rnd_word  (rnd_word),
    .rnd_valid (rnd_valid),
    .mode_cap  (mode_q)
);

// File: tb/test_rng_selectable.sv
module test_rng_selectable;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_load = 1'b0;
    logic [31:0] seed_val = '0;
    logic        mode_sel = 1'b0;
    logic        advance = 1'b0;
    logic [31:0] rnd_word;
    logic        rnd_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rng_selectable i_rng_selectable (
        .clk       (clk),
        .rst       (rst),
        .seed_load (seed_load),
        .seed_val  (seed_val),
        .mode_sel  (mode_sel),
        .advance   (advance),
        .rnd_word  (rnd_word),
        .rnd_valid (rnd_valid)
    );

    // Fields: {load, advance, mode, seed}
    localparam int NV = 14;
    localparam logic [34:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 32'd12345},
        {1'b0, 1'b1, 1'b0, 32'd0},
        {1'b0, 1'b1, 1'b0, 32'd0},
        {1'b1, 1'b0, 1'b1, 32'd7},
        {1'b0, 1'b1, 1'b1, 32'd0},
        {1'b0, 1'b1, 1'b1, 32'd0},
        {1'b0, 1'b0, 1'b1, 32'd0},
        {1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF},
        {1'b0, 1'b1, 1'b1, 32'd0},
        {1'b1, 1'b0, 1'b0, 32'h8000_0000},
        {1'b0, 1'b1, 1'b0, 32'd0},
        {1'b0, 1'b1, 1'b1, 32'd0},
        {1'b1, 1'b1, 1'b1, 32'hDEAD_BEEF},
        {1'b0, 1'b1, 1'b0, 32'd0}
    };

    function automatic logic [31:0] mdl_affine(input logic [31:0] s);
        logic [63:0] w;
        w = {32'd0, s} * 64'd2147001325 + 64'd715136305;
        return w[31:0];
    endfunction

    function automatic logic [31:0] mdl_shadd(input logic [31:0] s);
        logic [63:0] w;
        w = {32'd0, s} * 64'd65539 + 64'd1;
        return w[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", tag, act, act, exp, exp);
        end
    endtask

    // Entered at a falling edge; returns at the next falling edge.
    task automatic drive(input logic ld, input logic nx, input logic md, input logic [31:0] sd);
        seed_load = ld;
        advance   = nx;
        mode_sel  = md;
        seed_val  = sd;
        @(posedge clk);
        @(negedge clk);
        seed_load = 1'b0;
        advance   = 1'b0;
    endtask

    logic [31:0] m_state;
    logic        m_mode;
    logic        m_valid;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 word after reset", rnd_word, 32'd1);
        check("R1 valid after reset", {31'd0, rnd_valid}, 32'd0);
        drive(1'b0, 1'b1, 1'b1, 32'd0);
        check("R1 default affine step", rnd_word, 32'd2862137630);
        check("R8 valid after first step", {31'd0, rnd_valid}, 32'd1);
        m_state = rnd_word;
        m_mode  = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            if (VEC[i][34]) begin
                m_state = VEC[i][31:0];
                m_mode  = VEC[i][32];
                m_valid = 1'b0;
                tag = VEC[i][33] ? "R7 load beats step" : "R6 seed load";
            end else if (VEC[i][33]) begin
                m_state = m_mode ? mdl_shadd(m_state) : mdl_affine(m_state);
                m_valid = 1'b1;
                tag = m_mode ? "R3 shift-add step" : "R2 affine step";
            end else begin
                m_valid = 1'b0;
                tag = "R10 idle hold";
            end
            drive(VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:0]);
            check(tag, rnd_word, m_state);
            check("R8 valid vector", {31'd0, rnd_valid}, {31'd0, m_valid});
        end

        // R4 zero state in shift-add mode
        drive(1'b1, 1'b0, 1'b1, 32'd0);
        check("R6 zero seed", rnd_word, 32'd0);
        drive(1'b0, 1'b1, 1'b0, 32'd0);
        check("R4 zero escapes", rnd_word, 32'd1);

        // R5 new state presented, not old
        drive(1'b1, 1'b0, 1'b0, 32'd99);
        drive(1'b0, 1'b1, 1'b0, 32'd0);
        check("R5 new state shown", rnd_word, mdl_affine(32'd99));

        // R8 pulse then low while idle
        drive(1'b0, 1'b0, 1'b0, 32'd0);
        check("R8 valid drops when idle", {31'd0, rnd_valid}, 32'd0);
        check("R10 word held", rnd_word, mdl_affine(32'd99));

        // R9 mode flip without seed load is ignored
        drive(1'b1, 1'b0, 1'b1, 32'd5);
        drive(1'b0, 1'b1, 1'b0, 32'd0);
        check("R9 mode stays shift-add", rnd_word, mdl_shadd(32'd5));

        // R7 simultaneous strobes: no valid, seed taken
        drive(1'b1, 1'b1, 1'b0, 32'd42);
        check("R7 seed taken", rnd_word, 32'd42);
        check("R7 no valid", {31'd0, rnd_valid}, 32'd0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule